// File: doc/BRIEF.md
# I2C Bus Hang Recovery Controller

This block sits next to an I2C master and watches the two open-drain bus lines. It notices when the bus has stayed busy when it should not have. That happens when a noise glitch looked like a start condition and no stop ever followed, or when a slave stopped partway through a byte and is still holding SDA low. The block then takes over the bus. It clocks SCL until the slave lets go of SDA, puts a clean stop condition on the bus, and holds the master in reset for a few cycles so that the master can retry from a known state.

The decision to recover depends on a mode strap. With a single master on the bus, any "bus busy" refusal that the master reports is already an error, so recovery starts at once. With several masters, a refusal may be a legitimate transfer by another master. In that mode, recovery starts only after a programmable number of consecutive refusals, or after the bus has been busy for longer than the longest allowed transaction. A stop condition seen on the bus resets both of these measures.

All pins are plain control and status signals; there is no streaming interface and no back-pressure. The line drive outputs mean "pull low" and must feed open-drain pads.

Top module: `bus_unstick_ctrl`

## Requirements
- R1: Both lines pass through a two-flop synchronizer that resets to high. `bus_busy` goes to 1 when SDA falls while SCL is high, and goes to 0 when SDA rises while SCL is high. It goes to neither value on its own.
- R2: With `multi_master` = 0, a single `busy_refused` pulse while the controller is idle and not in fatal state starts recovery: `recovering` goes to 1 on the next clock edge.
- R3: With `multi_master` = 1, recovery starts on the refusal pulse that brings the count of refusals since the last stop to `refuse_limit`. Fewer refusals than that start nothing.
- R4: A stop condition seen on the bus clears the refusal count and the busy-time count.
- R5: With `multi_master` = 1, recovery starts when `bus_busy` has been 1 for `busy_timeout` consecutive cycles. With `multi_master` = 0, busy time never starts recovery.
- R6: When recovery starts with SDA low, SCL is pulled low and then released, each phase lasting `half_period` cycles. SDA is sampled at the end of each high phase, and pulsing stops at the first high phase in which SDA reads 1. At most 9 pulses are given.
- R7: When recovery starts with SDA already high, no pulses are given and the controller goes straight to the stop sequence.
- R8: The stop sequence pulls SCL low for one half period. It then pulls SDA low while SCL is still low, releases SCL, and releases SDA last, each step lasting one half period. The result is a valid stop, so `bus_busy` returns to 0.
- R9: If SDA still reads low at the end of the 9th pulse, `fatal_error` is set and both lines are released. No stop and no master reset follow. While `fatal_error` is 1, every trigger is ignored. Only `fatal_clear` or `rst_n` clears it.
- R10: After the stop sequence, `master_reset` is 1 for exactly `RST_CYCLES` consecutive cycles (4 by default) while both lines are released.
- R11: `recovering` is 1 from the start of recovery until the master reset ends or the fatal flag is set. The line pulls and `master_reset` are active only while `recovering` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pin | input | 1 | SCL level read from the pad (asynchronous) |
| sda_pin | input | 1 | SDA level read from the pad (asynchronous) |
| scl_pull_low | output | 1 | 1 pulls SCL low through the open-drain pad |
| sda_pull_low | output | 1 | 1 pulls SDA low through the open-drain pad |
| multi_master | input | 1 | Mode strap: 0 single master, 1 multi-master |
| busy_refused | input | 1 | One-cycle pulse each time the master is refused because the bus is busy |
| refuse_limit | input | CNT_W (8) | Refusal count that triggers recovery in multi-master mode |
| busy_timeout | input | TMO_W (20) | Busy-time limit in cycles for multi-master mode |
| half_period | input | HP_W (16) | Length of each SCL phase during recovery, in cycles |
| fatal_clear | input | 1 | Clears the fatal error flag |
| master_reset | output | 1 | Reset request to the I2C master |
| bus_busy | output | 1 | Bus busy state tracked from start and stop conditions |
| recovering | output | 1 | Recovery sequence in progress |
| fatal_error | output | 1 | Sticky flag: SDA stayed low after the maximum number of pulses |

## Verification
On every cycle, the assertions check the stop-sequence ordering: SDA is pulled only while SCL is already pulled, and SDA is released only after SCL is released. They also check that the fatal flag stays set until cleared, that triggers are refused while the controller is busy or in fatal state, that the pulse count stays bounded, and that both lines are released during the master reset. Only the bench scenarios can show the count-dependent outcomes. These include how many SCL pulses a slave that releases after a given number of clocks receives, when the refusal threshold and the busy timeout fire, how a stop clears the counts, and that `bus_busy` really drops after the generated stop. The bench models the slave as a wired-AND on both lines for these scenarios.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PULSE_LO,
    SQ_PULSE_HI,
    SQ_STOP_SCL,
    SQ_STOP_SDA,
    SQ_STOP_REL_SCL,
    SQ_STOP_REL_SDA,
    SQ_MRST
  } seq_state_t;
endpackage

// File: rtl/bus_line_watch.sv
module bus_line_watch #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_s,
  output logic sda_s,
  output logic bus_busy,
  output logic stop_seen
);
  logic [SYNC_DEPTH-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic start_seen;

  generate
    if (SYNC_DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_pin;
          sda_ff <= sda_pin;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_DEPTH-2:0], scl_pin};
          sda_ff <= {sda_ff[SYNC_DEPTH-2:0], sda_pin};
        end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_DEPTH-1];
  assign sda_s = sda_ff[SYNC_DEPTH-1];

  // SCL high across both samples, SDA edge between them
  assign start_seen = scl_s && scl_q && sda_q && !sda_s;
  assign stop_seen  = scl_s && scl_q && !sda_q && sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_seen)     bus_busy <= 1'b1;
      else if (stop_seen) bus_busy <= 1'b0;
    end

  // R1
  no_busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(sda_s) && $past(scl_s));
endmodule

// File: rtl/hang_trigger_policy.sv
module hang_trigger_policy #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             multi_master,
  input  logic             busy_refused,
  input  logic             bus_busy,
  input  logic             stop_seen,
  input  logic             accept,
  input  logic [CNT_W-1:0] refuse_limit,
  input  logic [TMO_W-1:0] busy_timeout,
  output logic             trigger
);
  logic [CNT_W-1:0] ref_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic [CNT_W:0]   ref_next;
  logic             ref_hit, tmo_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_cnt <= '0;
    else if (!accept || stop_seen) ref_cnt <= '0;
    else if (busy_refused && ref_cnt != '1) ref_cnt <= ref_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmo_cnt <= '0;
    else if (!accept || stop_seen || !bus_busy || !multi_master) tmo_cnt <= '0;
    else if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;

  assign ref_next = {1'b0, ref_cnt} + 1'b1;
  assign ref_hit  = busy_refused && (ref_next >= {1'b0, refuse_limit});
  assign tmo_hit  = bus_busy && (tmo_cnt >= busy_timeout);

  always_comb begin
    if (!accept)           trigger = 1'b0;
    else if (multi_master) trigger = ref_hit || tmo_hit;
    else                   trigger = busy_refused;
  end

  // R4
  no_stale_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (ref_cnt == '0) && (tmo_cnt == '0));
endmodule

// File: rtl/unstick_sequencer.sv
module unstick_sequencer
  import bus_unstick_pkg::*;
#(
  parameter int HP_W       = 16,
  parameter int MAX_PULSES = 9,
  parameter int RST_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trigger,
  input  logic            sda_s,
  input  logic [HP_W-1:0] half_period,
  input  logic            fatal_clear,
  output logic            accept,
  output logic            scl_pull_low,
  output logic            sda_pull_low,
  output logic            master_reset,
  output logic            recovering,
  output logic            fatal_error
);
  localparam int PC_W = $clog2(MAX_PULSES + 1);

  seq_state_t state_q, state_d;
  logic [HP_W-1:0] dwell_q, hp_load;
  logic [PC_W-1:0] pcnt_q;
  logic            fatal_q, fatal_set, pcnt_inc, phase_end;

  assign hp_load   = (half_period == '0) ? '0 : half_period - 1'b1;
  assign phase_end = (dwell_q == '0);
  assign accept    = (state_q == SQ_IDLE) && !fatal_q;

  always_comb begin
    state_d   = state_q;
    fatal_set = 1'b0;
    pcnt_inc  = 1'b0;
    case (state_q)
      SQ_IDLE:
        if (trigger && accept) state_d = sda_s ? SQ_STOP_SCL : SQ_PULSE_LO;
      SQ_PULSE_LO:
        if (phase_end) state_d = SQ_PULSE_HI;
      SQ_PULSE_HI:
        if (phase_end) begin
          if (sda_s) state_d = SQ_STOP_SCL;
          else if (pcnt_q == PC_W'(MAX_PULSES - 1)) begin
            state_d   = SQ_IDLE;
            fatal_set = 1'b1;
          end else begin
            state_d  = SQ_PULSE_LO;
            pcnt_inc = 1'b1;
          end
        end
      SQ_STOP_SCL:     if (phase_end) state_d = SQ_STOP_SDA;
      SQ_STOP_SDA:     if (phase_end) state_d = SQ_STOP_REL_SCL;
      SQ_STOP_REL_SCL: if (phase_end) state_d = SQ_STOP_REL_SDA;
      SQ_STOP_REL_SDA: if (phase_end) state_d = SQ_MRST;
      SQ_MRST:         if (phase_end) state_d = SQ_IDLE;
      default:         state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      dwell_q <= '0;
      pcnt_q  <= '0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q || pcnt_inc)
        dwell_q <= (state_d == SQ_MRST) ? HP_W'(RST_CYCLES - 1) : hp_load;
      else if (dwell_q != '0)
        dwell_q <= dwell_q - 1'b1;
      if (state_q == SQ_IDLE)  pcnt_q <= '0;
      else if (pcnt_inc)       pcnt_q <= pcnt_q + 1'b1;
      if (fatal_set)           fatal_q <= 1'b1;
      else if (fatal_clear)    fatal_q <= 1'b0;
    end

  assign scl_pull_low = (state_q == SQ_PULSE_LO) || (state_q == SQ_STOP_SCL) ||
                        (state_q == SQ_STOP_SDA);
  assign sda_pull_low = (state_q == SQ_STOP_SDA) || (state_q == SQ_STOP_REL_SCL);
  assign master_reset = (state_q == SQ_MRST);
  assign recovering   = (state_q != SQ_IDLE);
  assign fatal_error  = fatal_q;

  // R8
  sda_after_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(scl_pull_low));
  // R8
  sda_release_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_low) |-> !scl_pull_low);
  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_error && !fatal_clear |=> fatal_error);
  // R9
  no_trigger_in_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_error && !recovering |=> !recovering);
  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < PC_W'(MAX_PULSES));
  // R10
  lines_free_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_reset |-> !scl_pull_low && !sda_pull_low);
endmodule

// File: rtl/bus_unstick_ctrl.sv
module bus_unstick_ctrl #(
  parameter int CNT_W      = 8,
  parameter int TMO_W      = 20,
  parameter int HP_W       = 16,
  parameter int MAX_PULSES = 9,
  parameter int RST_CYCLES = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_pin,
  input  logic             sda_pin,
  output logic             scl_pull_low,
  output logic             sda_pull_low,
  input  logic             multi_master,
  input  logic             busy_refused,
  input  logic [CNT_W-1:0] refuse_limit,
  input  logic [TMO_W-1:0] busy_timeout,
  input  logic [HP_W-1:0]  half_period,
  input  logic             fatal_clear,
  output logic             master_reset,
  output logic             bus_busy,
  output logic             recovering,
  output logic             fatal_error
);
  logic scl_s, sda_s, stop_seen, accept, trigger;

  bus_line_watch #(.SYNC_DEPTH(SYNC_DEPTH)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy), .stop_seen(stop_seen)
  );

  hang_trigger_policy #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_policy (
    .clk(clk), .rst_n(rst_n), .multi_master(multi_master),
    .busy_refused(busy_refused), .bus_busy(bus_busy), .stop_seen(stop_seen),
    .accept(accept), .refuse_limit(refuse_limit), .busy_timeout(busy_timeout),
    .trigger(trigger)
  );

  unstick_sequencer #(.HP_W(HP_W), .MAX_PULSES(MAX_PULSES), .RST_CYCLES(RST_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .sda_s(sda_s),
    .half_period(half_period), .fatal_clear(fatal_clear), .accept(accept),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .master_reset(master_reset), .recovering(recovering), .fatal_error(fatal_error)
  );

  // R11
  drive_only_recovering_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_low || sda_pull_low || master_reset) |-> recovering);
  // R2
  single_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_refused && !multi_master && !recovering && !fatal_error |=> recovering);
endmodule

// File: tb/bus_unstick_ctrl_tb_top.sv
module bus_unstick_ctrl_tb_top;
  localparam int HP  = 4;
  localparam int RST = 4;

  typedef struct {
    int rises;
    bit fatal;
    int rst_cyc;
    bit busy_after;
    int first_low;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic tb_scl_low = 0, tb_sda_low = 0, slave_hold = 0;
  logic multi_master = 0, busy_refused = 0, fatal_clear = 0;
  logic [7:0]  refuse_limit = 8'd3;
  logic [19:0] busy_timeout = 20'd100;
  logic [15:0] half_period = 16'(HP);
  logic scl_pull_low, sda_pull_low, master_reset, bus_busy, recovering, fatal_error;
  logic scl_w, sda_w;

  int tests = 0, fails = 0, cycle = 0;
  int slave_need = 0, slave_falls = 0;
  int rec_start = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  assign scl_w = !(scl_pull_low || tb_scl_low);
  assign sda_w = !(sda_pull_low || tb_sda_low || slave_hold);

  bus_unstick_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_w), .sda_pin(sda_w),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .multi_master(multi_master), .busy_refused(busy_refused),
    .refuse_limit(refuse_limit), .busy_timeout(busy_timeout),
    .half_period(half_period), .fatal_clear(fatal_clear),
    .master_reset(master_reset), .bus_busy(bus_busy),
    .recovering(recovering), .fatal_error(fatal_error)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // slave model: holds SDA until it has seen slave_need SCL falling edges
  logic sl_prev_scl = 1;
  always @(negedge clk) begin
    if (slave_hold && sl_prev_scl && !scl_w) begin
      slave_falls++;
      if (slave_falls >= slave_need) slave_hold <= 0;
    end
    sl_prev_scl <= scl_w;
  end

  // monitor: measures each recovery and compares with the queued expectation
  logic m_prev_rec = 0, m_prev_scl = 1, m_prev_sdap = 0;
  int m_rises, m_rst, m_low, m_first_low;
  bit m_first_done, m_bad_order, m_stray = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!recovering && (scl_pull_low || sda_pull_low || master_reset)) m_stray = 1;
      if (recovering && !m_prev_rec) begin
        m_rises = 0; m_rst = 0; m_low = 0; m_first_low = 0;
        m_first_done = 0; m_bad_order = 0; rec_start = cycle;
      end
      if (recovering) begin
        if (scl_w && !m_prev_scl) begin
          m_rises++;
          if (!m_first_done) begin m_first_low = m_low; m_first_done = 1; end
        end
        if (!scl_w && !m_first_done) m_low++;
        if (master_reset) m_rst++;
        if (sda_pull_low && !m_prev_sdap && scl_w) m_bad_order = 1;
      end
      if (!recovering && m_prev_rec) begin
        if (q.size() == 0) chk(0, "R11 unexpected recovery", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(m_rises == e.rises, {e.tag, " R6 SCL rises"}, m_rises, e.rises);
          chk(fatal_error == e.fatal, {e.tag, " R9 fatal flag"}, fatal_error, e.fatal);
          chk(m_rst == e.rst_cyc, {e.tag, " R10 master reset cycles"}, m_rst, e.rst_cyc);
          chk(bus_busy == e.busy_after, {e.tag, " R8 busy after"}, bus_busy, e.busy_after);
          chk(m_first_low == e.first_low, {e.tag, " R6 first low phase"}, m_first_low, e.first_low);
          chk(!m_bad_order, {e.tag, " R8 SDA pulled while SCL high"}, m_bad_order, 0);
          chk(!m_stray, {e.tag, " R11 drive outside recovery"}, m_stray, 0);
        end
      end
      m_prev_rec  <= recovering;
      m_prev_scl  <= scl_w;
      m_prev_sdap <= sda_pull_low;
    end
  end

  task automatic expect_rec(input int rises, input bit fatal, input int rc,
                            input bit busy_after, input int first_low, input string tag);
    exp_t e;
    e.rises = rises; e.fatal = fatal; e.rst_cyc = rc;
    e.busy_after = busy_after; e.first_low = first_low; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_drain();
    int n = 0;
    while (q.size() != 0 && n < 5000) begin cyc(1); n++; end
    cyc(4);
  endtask

  task automatic refuse();
    @(posedge clk); #1 busy_refused = 1;
    @(posedge clk); #1 busy_refused = 0;
  endtask

  task automatic spurious_start();
    tb_sda_low = 1; cyc(6);
    tb_scl_low = 1; cyc(6);
    tb_sda_low = 0; cyc(6);
    tb_scl_low = 0; cyc(6);
  endtask

  task automatic make_stop();
    tb_scl_low = 1; tb_sda_low = 1; cyc(6);
    tb_scl_low = 0; cyc(6);
    tb_sda_low = 0; cyc(6);
  endtask

  task automatic arm_slave(input int k);
    tb_sda_low = 1; cyc(6);
    tb_scl_low = 1; cyc(6);
    slave_need = k; slave_falls = 0; slave_hold = 1;
    tb_sda_low = 0; cyc(6);
    tb_scl_low = 0; cyc(6);
  endtask

  // a slave that needs k falling edges gets k pulses plus the stop rise
  task automatic stuck_case(input int k);
    arm_slave(k);
    chk(bus_busy == 1, "R1 busy with stuck slave", bus_busy, 1);
    expect_rec(k + 1, 0, RST, 0, HP, $sformatf("R6 stuck k=%0d", k));
    refuse();
    wait_drain();
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk(bus_busy == 0, "R1 reset busy", bus_busy, 0);
    chk(recovering == 0, "R11 reset recovering", recovering, 0);
    chk(fatal_error == 0, "R9 reset fatal", fatal_error, 0);
    chk(!scl_pull_low && !sda_pull_low, "R11 reset drives", scl_pull_low, 0);
    chk(master_reset == 0, "R10 reset master_reset", master_reset, 0);

    // single master: busy time alone does nothing (R5), one refusal recovers (R2, R7)
    spurious_start();
    chk(bus_busy == 1, "R1 busy after spurious start", bus_busy, 1);
    cyc(200);
    chk(recovering == 0, "R5 no timeout in single mode", recovering, 0);
    chk(bus_busy == 1, "R1 busy never self-clears", bus_busy, 1);
    expect_rec(1, 0, RST, 0, 2 * HP, "R2 R7 direct stop");
    refuse();
    wait_drain();

    // stuck slaves (R6), including the largest count that still succeeds
    stuck_case(1);
    stuck_case(4);
    stuck_case(9);

    // never releases: fatal after 9 pulses (R9)
    arm_slave(20);
    expect_rec(9, 1, 0, 1, HP, "R9 fatal");
    refuse();
    wait_drain();
    refuse();
    cyc(10);
    chk(recovering == 0, "R9 trigger ignored in fatal", recovering, 0);
    chk(fatal_error == 1, "R9 fatal stays set", fatal_error, 1);
    @(posedge clk); #1 fatal_clear = 1;
    @(posedge clk); #1 fatal_clear = 0;
    cyc(2);
    chk(fatal_error == 0, "R9 fatal cleared", fatal_error, 0);
    slave_hold = 0;
    cyc(6);
    chk(bus_busy == 0, "R1 stop from released slave", bus_busy, 0);

    // multi-master refusal threshold (R3) and clear by stop (R4)
    multi_master = 1; refuse_limit = 8'd3; busy_timeout = 20'd100000;
    spurious_start();
    refuse(); refuse();
    cyc(10);
    chk(recovering == 0, "R3 below threshold", recovering, 0);
    make_stop();
    chk(bus_busy == 0, "R1 stop clears busy", bus_busy, 0);
    spurious_start();
    refuse(); refuse();
    cyc(10);
    chk(recovering == 0, "R4 count restarted after stop", recovering, 0);
    expect_rec(1, 0, RST, 0, 2 * HP, "R3 threshold reached");
    refuse();
    wait_drain();

    // multi-master busy timeout (R5)
    busy_timeout = 20'd300;
    expect_rec(1, 0, RST, 0, 2 * HP, "R5 timeout");
    begin
      int c0;
      c0 = cycle;
      spurious_start();
      wait_drain();
      chk((rec_start - c0 >= 300) && (rec_start - c0 <= 310),
          "R5 timeout latency", rec_start - c0, 305);
    end

    chk(q.size() == 0, "R11 all recoveries seen", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule